// File: doc/BRIEF.md
# Shared-Way Reservation Adjuster

This block sits beside a private cache and decides which ways of each set are held back for lines in a shared coherence state. It holds one reservation mask per set, one bit per way, and a live count of the shared lines resident in each set. The count follows fill and eviction events that carry a shared flag. The replacement logic reads the mask of a set through a query port and keeps private fills out of the reserved ways.

A coherence controller sends grow and shrink commands. On a grow command the block walks all sets one at a time and picks, one after another, the sets with the most shared lines among those that can still take another reserved way. In each chosen set it turns on one way that is currently free. On a shrink command it picks the sets with the fewest shared lines among those that have any reserved way, and it frees one reserved way in each. The way that changes is found by starting at a position taken from a free-running 16-bit LFSR and moving upward, with wrap-around, to the first way that qualifies. While a command runs, `busy` is high and further commands are dropped. Count updates go on during that time.

Top module: `resv_adjust_ctrl`

## Requirements
- R1: After reset every reservation mask reads zero, every shared-line count reads zero and `busy` is low.
- R2: A fill with `fill_shared`=1 adds one to the count of `fill_set`, and an eviction with `evict_shared`=1 takes one from the count of `evict_set`. Events with the shared flag at 0 change no count. A shared fill and a shared eviction to the same set in the same cycle leave that count unchanged.
- R3: A count never exceeds WAYS and never goes below zero. An increment at WAYS and a decrement at zero are dropped.
- R4: On a grow command (`cmd_valid`=1, `cmd_grow`=1 while idle), the eligible sets are ranked by count, highest first, with equal counts ordered by lower set index. Up to PICKS of them are chosen. Each chosen set gets exactly one mask bit changed from 0 to 1, and no other mask changes.
- R5: A set is eligible for grow only while fewer than WAYS-1 of its mask bits are set, so at least one way of every set always stays unreserved.
- R6: On a shrink command (`cmd_grow`=0), the sets with a nonzero mask are ranked by count, lowest first, with equal counts ordered by lower set index. Up to PICKS of them are chosen. Each chosen set gets exactly one mask bit changed from 1 to 0, and no other mask changes.
- R7: When fewer than PICKS sets are eligible, only those are edited. When none is eligible, the command completes with no mask changed.
- R8: `busy` is high from the cycle after a command is accepted until the command's last mask edit is visible. A command presented while `busy` is high is ignored.
- R9: Fill and eviction events update the counts while a command is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_grow | input | 1 | 1 = grow reservations, 0 = shrink |
| fill_valid | input | 1 | A line was filled into a set |
| fill_set | input | SET_W | Set index of the fill |
| fill_shared | input | 1 | The filled line is in a shared state |
| evict_valid | input | 1 | A line was evicted from a set |
| evict_set | input | SET_W | Set index of the eviction |
| evict_shared | input | 1 | The evicted line was in a shared state |
| qry_set | input | SET_W | Set index to look up |
| qry_vec | output | WAYS | Reservation mask of `qry_set` (combinational) |
| qry_cnt | output | CNT_W | Shared-line count of `qry_set` (combinational) |
| busy | output | 1 | A command is being carried out |

## Verification
On every cycle the assertions check the following: each mask write flips exactly one bit, in the direction the command asks for; a write never fills a set's last free way; every write finds a candidate bit; a count never passes WAYS; and an accepted command raises `busy`. The ranking cannot be seen from any single cycle: only the bench's scenarios show it. These cover which sets win under distinct and tied counts, the exclusion of full or empty sets, the runs that end with nothing eligible, a command dropped mid-run and counts updated mid-run. The bench works out the winners arithmetically from its own model of the counts and masks, and checks every set's mask after each command.

// File: rtl/resv_adj_pkg.sv
package resv_adj_pkg;

    typedef enum logic [1:0] {
        ADJ_IDLE  = 2'd0,
        ADJ_SCAN  = 2'd1,
        ADJ_WRITE = 2'd2
    } adj_state_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/resv_adj_lfsr.sv
module resv_adj_lfsr #(
    parameter int WAYS = 8,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [WIDX-1:0] start_way
);
    import resv_adj_pkg::*;

    logic [15:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= LFSR_SEED;
        else        lfsr_q <= lfsr_d;
    end

    assign start_way = WIDX'(lfsr_q % 16'(WAYS));

endmodule

// File: rtl/resv_adj_counters.sv
module resv_adj_counters #(
    parameter int NUM_SETS = 32,
    parameter int WAYS     = 8,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int CNT_W   = $clog2(WAYS + 1)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             fill_valid,
    input  logic [SET_W-1:0]                 fill_set,
    input  logic                             fill_shared,
    input  logic                             evict_valid,
    input  logic [SET_W-1:0]                 evict_set,
    input  logic                             evict_shared,
    output logic [NUM_SETS-1:0][CNT_W-1:0]   cnt
);

    for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
        logic             up, down;
        logic [CNT_W-1:0] cnt_d, cnt_q;

        always_comb begin
            up    = fill_valid  && fill_shared  && (fill_set  == SET_W'(s));
            down  = evict_valid && evict_shared && (evict_set == SET_W'(s));
            cnt_d = cnt_q;
            if (up && !down && (cnt_q < CNT_W'(WAYS))) begin
                cnt_d = cnt_q + CNT_W'(1);
            end else if (down && !up && (cnt_q != '0)) begin
                cnt_d = cnt_q - CNT_W'(1);
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_d;
        end

        assign cnt[s] = cnt_q;
    end

endmodule

// File: rtl/resv_adj_bitpick.sv
module resv_adj_bitpick #(
    parameter int WAYS = 8,
    localparam int WIDX = $clog2(WAYS)
) (
    input  logic [WAYS-1:0] old_vec,
    input  logic            grow,
    input  logic [WIDX-1:0] start_way,
    output logic [WAYS-1:0] new_vec,
    output logic            hit
);

    logic [WAYS-1:0] cand;

    always_comb begin
        cand    = grow ? ~old_vec : old_vec;
        new_vec = old_vec;
        hit     = 1'b0;
        for (int i = 0; i < WAYS; i++) begin
            int p;
            p = (int'(start_way) + i) % WAYS;
            if (!hit && cand[p]) begin
                hit        = 1'b1;
                new_vec[p] = grow;
            end
        end
    end

endmodule

// File: rtl/resv_adjust_ctrl.sv
module resv_adjust_ctrl #(
    parameter int NUM_SETS = 32,
    parameter int WAYS     = 8,
    parameter int PICKS    = 10,
    localparam int SET_W   = $clog2(NUM_SETS),
    localparam int CNT_W   = $clog2(WAYS + 1),
    localparam int PICK_W  = $clog2(PICKS + 1),
    localparam int WIDX    = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_grow,
    input  logic             fill_valid,
    input  logic [SET_W-1:0] fill_set,
    input  logic             fill_shared,
    input  logic             evict_valid,
    input  logic [SET_W-1:0] evict_set,
    input  logic             evict_shared,
    input  logic [SET_W-1:0] qry_set,
    output logic [WAYS-1:0]  qry_vec,
    output logic [CNT_W-1:0] qry_cnt,
    output logic             busy
);
    import resv_adj_pkg::*;

    typedef struct packed {
        adj_state_e                        st;
        logic                              grow;
        logic [SET_W-1:0]                  idx;
        logic [SET_W-1:0]                  best_idx;
        logic [CNT_W-1:0]                  best_cnt;
        logic                              best_ok;
        logic [PICK_W-1:0]                 picks;
        logic [NUM_SETS-1:0]               done;
        logic [NUM_SETS-1:0][WAYS-1:0]     vecs;
    } ctl_s;

    ctl_s s_d, s_q;

    logic [NUM_SETS-1:0][CNT_W-1:0] cnt_all;
    logic [WIDX-1:0]                start_way;
    logic [WAYS-1:0]                old_vec, new_vec, cur_vec;
    logic [CNT_W-1:0]               cur_cnt;
    logic                           pick_hit, wr_en, elig, better;

    resv_adj_counters #(.NUM_SETS(NUM_SETS), .WAYS(WAYS)) u_cnt (
        .clk          (clk),
        .rst_n        (rst_n),
        .fill_valid   (fill_valid),
        .fill_set     (fill_set),
        .fill_shared  (fill_shared),
        .evict_valid  (evict_valid),
        .evict_set    (evict_set),
        .evict_shared (evict_shared),
        .cnt          (cnt_all)
    );

    resv_adj_lfsr #(.WAYS(WAYS)) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_way (start_way)
    );

    assign old_vec = s_q.vecs[s_q.best_idx];

    resv_adj_bitpick #(.WAYS(WAYS)) u_pick (
        .old_vec   (old_vec),
        .grow      (s_q.grow),
        .start_way (start_way),
        .new_vec   (new_vec),
        .hit       (pick_hit)
    );

    always_comb begin
        s_d     = s_q;
        wr_en   = 1'b0;
        cur_cnt = cnt_all[s_q.idx];
        cur_vec = s_q.vecs[s_q.idx];
        if (s_q.grow) begin
            elig   = !s_q.done[s_q.idx] && ($countones(cur_vec) < WAYS - 1);
            better = !s_q.best_ok || (cur_cnt > s_q.best_cnt);
        end else begin
            elig   = !s_q.done[s_q.idx] && (cur_vec != '0);
            better = !s_q.best_ok || (cur_cnt < s_q.best_cnt);
        end

        unique case (s_q.st)
            ADJ_IDLE: begin
                if (cmd_valid) begin
                    s_d.st      = ADJ_SCAN;
                    s_d.grow    = cmd_grow;
                    s_d.idx     = '0;
                    s_d.best_ok = 1'b0;
                    s_d.picks   = '0;
                    s_d.done    = '0;
                end
            end
            ADJ_SCAN: begin
                if (elig && better) begin
                    s_d.best_idx = s_q.idx;
                    s_d.best_cnt = cur_cnt;
                    s_d.best_ok  = 1'b1;
                end
                if (s_q.idx == SET_W'(NUM_SETS - 1)) begin
                    s_d.st = ADJ_WRITE;
                end else begin
                    s_d.idx = s_q.idx + SET_W'(1);
                end
            end
            ADJ_WRITE: begin
                if (s_q.best_ok) begin
                    wr_en                   = 1'b1;
                    s_d.vecs[s_q.best_idx]  = new_vec;
                    s_d.done[s_q.best_idx]  = 1'b1;
                    s_d.picks               = s_q.picks + PICK_W'(1);
                end
                if (!s_q.best_ok || (s_q.picks == PICK_W'(PICKS - 1))) begin
                    s_d.st = ADJ_IDLE;
                end else begin
                    s_d.st      = ADJ_SCAN;
                    s_d.idx     = '0;
                    s_d.best_ok = 1'b0;
                end
            end
            default: s_d.st = ADJ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign qry_vec = s_q.vecs[qry_set];
    assign qry_cnt = cnt_all[qry_set];
    assign busy    = (s_q.st != ADJ_IDLE);

endmodule

// File: rtl/resv_adjust_chk.sv
module resv_adjust_chk #(
    parameter int WAYS   = 8,
    parameter int PICKS  = 10,
    parameter int CNT_W  = 4,
    parameter int PICK_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              wr_en,
    input logic              wr_grow,
    input logic [WAYS-1:0]   old_vec,
    input logic [WAYS-1:0]   new_vec,
    input logic              pick_hit,
    input logic [CNT_W-1:0]  qry_cnt,
    input logic [PICK_W-1:0] picks
);

    AST_ONE_BIT_EDIT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(old_vec ^ new_vec) == 1)); // R4

    AST_GROW_ONLY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_grow) |-> ((new_vec & old_vec) == old_vec)); // R4

    AST_SHRINK_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_grow) |-> ((new_vec & old_vec) == new_vec)); // R6

    AST_FREE_WAY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ($countones(new_vec) <= WAYS - 1)); // R5

    AST_CANDIDATE_FOUND: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> pick_hit); // R7

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        qry_cnt <= CNT_W'(WAYS)); // R3

    AST_CMD_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy); // R8

    AST_PICK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        picks <= PICK_W'(PICKS)); // R7

    AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !wr_en); // R8

endmodule

bind resv_adjust_ctrl resv_adjust_chk #(
    .WAYS   (WAYS),
    .PICKS  (PICKS),
    .CNT_W  (CNT_W),
    .PICK_W (PICK_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .wr_en     (wr_en),
    .wr_grow   (s_q.grow),
    .old_vec   (old_vec),
    .new_vec   (new_vec),
    .pick_hit  (pick_hit),
    .qry_cnt   (qry_cnt),
    .picks     (s_q.picks)
);

// File: tb/tb_resv_adjust_ctrl.sv
`timescale 1ns/1ps
module tb_resv_adjust_ctrl;
    localparam int NS = 16;
    localparam int WY = 4;
    localparam int PK = 3;
    localparam int SW = $clog2(NS);
    localparam int CW = $clog2(WY + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0, cmd_grow = 1'b0;
    logic          fill_valid = 1'b0, fill_shared = 1'b0;
    logic          evict_valid = 1'b0, evict_shared = 1'b0;
    logic [SW-1:0] fill_set = '0, evict_set = '0, qry_set = '0;
    logic [WY-1:0] qry_vec;
    logic [CW-1:0] qry_cnt;
    logic          busy;

    int total = 0;
    int bad   = 0;
    int          mc[NS];
    logic [WY-1:0] mv[NS];
    bit          exp_sel[NS];

    always #2 clk = ~clk;

    resv_adjust_ctrl #(.NUM_SETS(NS), .WAYS(WY), .PICKS(PK)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_grow(cmd_grow),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_shared(fill_shared),
        .evict_valid(evict_valid), .evict_set(evict_set), .evict_shared(evict_shared),
        .qry_set(qry_set), .qry_vec(qry_vec), .qry_cnt(qry_cnt), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic read_set(input int s, output logic [WY-1:0] v, output int c);
        @(negedge clk);
        qry_set = SW'(s);
        #1;
        v = qry_vec;
        c = int'(qry_cnt);
    endtask

    task automatic event_cycle(input bit f, input int fs, input bit fsh,
                               input bit e, input int es, input bit esh);
        @(negedge clk);
        fill_valid = f;  fill_set  = SW'(fs); fill_shared  = fsh;
        evict_valid = e; evict_set = SW'(es); evict_shared = esh;
        @(negedge clk);
        fill_valid = 1'b0; evict_valid = 1'b0;
        if (!(f && e && fsh && esh && fs == es)) begin
            if (f && fsh && mc[fs] < WY) mc[fs]++;
            if (e && esh && mc[es] > 0)  mc[es]--;
        end
    endtask

    task automatic compute_sel(input bit grow);
        for (int s = 0; s < NS; s++) exp_sel[s] = 1'b0;
        for (int k = 0; k < PK; k++) begin
            int b;
            b = -1;
            for (int s = 0; s < NS; s++) begin
                bit el;
                el = grow ? ($countones(mv[s]) < WY - 1) : (mv[s] != '0);
                if (!exp_sel[s] && el &&
                    (b < 0 || (grow ? (mc[s] > mc[b]) : (mc[s] < mc[b]))))
                    b = s;
            end
            if (b >= 0) exp_sel[b] = 1'b1;
        end
    endtask

    task automatic run_round(input bit grow, input bit rank, input bit extra_cmd,
                             input bit fill_during);
        int changed;
        string rq;
        rq = grow ? "R4" : "R6";
        if (rank) compute_sel(grow);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_grow = grow;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy === 1'b1, "R8 busy after command", int'(busy), 1);
        if (extra_cmd) begin
            cmd_valid = 1'b1; cmd_grow = !grow;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        if (fill_during) event_cycle(1'b1, 5, 1'b1, 1'b0, 0, 1'b0);
        while (busy) @(negedge clk);
        changed = 0;
        for (int s = 0; s < NS; s++) begin
            logic [WY-1:0] v, d;
            int c;
            bit dir_ok;
            read_set(s, v, c);
            d = v ^ mv[s];
            dir_ok = grow ? ((v & mv[s]) == mv[s]) : ((v & mv[s]) == v);
            if (d != '0) changed++;
            if (rank && exp_sel[s])
                check(($countones(d) == 1) && dir_ok, rq, int'(v), int'(mv[s]));
            else if (rank)
                check(v == mv[s], "R7 unchosen set unchanged", int'(v), int'(mv[s]));
            else
                check(($countones(d) <= 1) && dir_ok, rq, int'(v), int'(mv[s]));
            if (grow) check($countones(v) <= WY - 1, "R5 free way kept", $countones(v), WY - 1);
            mv[s] = v;
        end
        if (!rank) check(changed <= PK, "R8 single run", changed, PK);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [WY-1:0] v;
        int c;
        for (int s = 0; s < NS; s++) begin mc[s] = 0; mv[s] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check(busy === 1'b0, "R1 busy", int'(busy), 0);
        for (int s = 0; s < NS; s++) begin
            read_set(s, v, c);
            check(v == '0 && c == 0, "R1 reset", int'(v) * 100 + c, 0);
        end

        // R2: shared fills build counts, non-shared events ignored
        for (int s = 0; s < NS; s++) begin
            for (int k = 0; k < (s * 7) % (WY + 1); k++)
                event_cycle(1'b1, s, 1'b1, 1'b0, 0, 1'b0);
            event_cycle(1'b1, s, 1'b0, 1'b1, s, 1'b0);
        end
        for (int s = 0; s < NS; s++) begin
            read_set(s, v, c);
            check(c == (s * 7) % (WY + 1), "R2 count", c, (s * 7) % (WY + 1));
        end
        // R2: simultaneous shared fill and evict on one set
        event_cycle(1'b1, 3, 1'b1, 1'b1, 3, 1'b1);
        read_set(3, v, c);
        check(c == mc[3], "R2 same-cycle cancel", c, mc[3]);
        // R2: shared evict decrements
        event_cycle(1'b0, 0, 1'b0, 1'b1, 3, 1'b1);
        read_set(3, v, c);
        check(c == mc[3], "R2 evict", c, mc[3]);

        // R3: saturation at WY and floor at zero on set 0
        for (int k = 0; k < WY + 2; k++) event_cycle(1'b1, 0, 1'b1, 1'b0, 0, 1'b0);
        read_set(0, v, c);
        check(c == WY, "R3 ceiling", c, WY);
        for (int k = 0; k < WY + 2; k++) event_cycle(1'b0, 0, 1'b0, 1'b1, 0, 1'b1);
        read_set(0, v, c);
        check(c == 0, "R3 floor", c, 0);
        event_cycle(1'b1, 0, 1'b1, 1'b0, 0, 1'b0);

        // R4 R5 R7: grow rounds until every set is at its limit, then beyond
        for (int r = 0; r < NS + 2; r++) run_round(1'b1, 1'b1, 1'b0, 1'b0);
        for (int s = 0; s < NS; s++)
            check($countones(mv[s]) == WY - 1, "R5 limit reached", $countones(mv[s]), WY - 1);

        // R6 R7: shrink rounds until every mask is empty, then beyond
        for (int r = 0; r < NS + 2; r++) run_round(1'b0, 1'b1, 1'b0, 1'b0);
        for (int s = 0; s < NS; s++)
            check(mv[s] == '0, "R7 all cleared", int'(mv[s]), 0);

        // R8: a second command during busy is ignored
        run_round(1'b1, 1'b1, 1'b1, 1'b0);
        run_round(1'b1, 1'b1, 1'b1, 1'b0);

        // R9: count update while busy
        run_round(1'b1, 1'b0, 1'b0, 1'b1);
        read_set(5, v, c);
        check(c == mc[5], "R9 count during busy", c, mc[5]);

        // R6: shrink with tied counts after equalising all sets
        for (int s = 0; s < NS; s++)
            while (mc[s] > 1) event_cycle(1'b0, 0, 1'b0, 1'b1, s, 1'b1);
        for (int s = 0; s < NS; s++)
            while (mc[s] < 1) event_cycle(1'b1, s, 1'b1, 1'b0, 0, 1'b0);
        run_round(1'b0, 1'b1, 1'b0, 1'b0);
        run_round(1'b1, 1'b1, 1'b0, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule